// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block is the sending side of an inter-processor interrupt path. Software programs a pair of 32-bit command words through a simple register port. The high word carries the target controller identifier. A write to the low word is the trigger: it takes the vector, delivery mode, trigger and polarity flags and destination shorthand from the written data, joins them with the stored target identifier, and posts the finished message on a valid/ready output.

A status bit in the low word reads as 1 from launch until the downstream message port takes the message. Software polls it before it issues the next command. While a message is pending, further low-word writes are dropped. The unit decodes the all-including-self shorthand into a broadcast flag, and it expands the vector of a start-up message into a page-aligned start address.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `msg_valid` is 0 and both command words (low at byte offset 0x300, high at 0x310) read as 0.
- R2: A write to the high word stores all 32 bits, which read back unchanged. It never raises `msg_valid`.
- R3: A low-word write while idle raises `msg_valid` on the next cycle. The message takes its fields from the written word: vector = bits 7:0, delivery mode = bits 10:8 (0 fixed, 5 INIT, 6 STARTUP), assert = bit 14, level = bit 15, shorthand = bits 19:18. The target comes from high-word bits 31:24.
- R4: Reading the low word returns the last accepted low-word value, with bit 12 replaced by the live status: 1 while a message is pending, 0 otherwise. A 1 written to bit 12 is not kept.
- R5: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and every message field hold steady.
- R6: On the cycle after a clock edge with `msg_valid` and `msg_ready` both 1, `msg_valid` and the status bit are 0.
- R7: A low-word write while a message is pending changes nothing: neither the message nor the low-word read-back.
- R8: Shorthand 2'b10 (low-word value 0x80000) sets `msg_to_all` and forces `msg_dest` to 8'hFF, whatever the high word holds. Other shorthands leave `msg_to_all` at 0.
- R9: For delivery mode 6, `msg_start_addr` equals the vector shifted left by 12. For every other mode it is 0.
- R10: A high-word write while a message is pending does not change the target of that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| msg_valid | output | 1 | Message pending on the output |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_dest | output | 8 | Target identifier (8'hFF on broadcast) |
| msg_vector | output | 8 | Vector number |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level-triggered flag |
| msg_assert | output | 1 | Assert (1) or de-assert (0) |
| msg_shorthand | output | 2 | Raw destination shorthand |
| msg_to_all | output | 1 | Deliver to every controller including the sender |
| msg_start_addr | output | 20 | Start address for STARTUP messages |

## Verification
The bench issues a low-word write while a message is still pending. A design that failed to drop it would overwrite the vector in flight or the read-back. It also rewrites the high word mid-flight; a design that read the target live, instead of capturing it at launch, would change the destination of the pending message. Other tests check that the status bit reads 1 exactly until acceptance, that a written bit 12 does not stick, that broadcast overrides a non-FF target, and that INIT de-assert keeps level set while assert clears. A STARTUP message must carry its page-aligned address, and a fixed message must carry none.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
    localparam int WORD_W     = 32;
    localparam int VEC_W      = 8;
    localparam int ID_W       = 8;
    localparam int MODE_W     = 3;
    localparam int SH_W       = 2;
    localparam int PAGE_SHIFT = 12;
    localparam int START_W    = VEC_W + PAGE_SHIFT;
    localparam int STATUS_BIT = 12;

    localparam logic [MODE_W-1:0] MODE_FIXED   = 3'd0;
    localparam logic [MODE_W-1:0] MODE_INIT    = 3'd5;
    localparam logic [MODE_W-1:0] MODE_STARTUP = 3'd6;
    localparam logic [SH_W-1:0]   SH_ALL_SELF  = 2'b10;
    localparam logic [ID_W-1:0]   ID_ALL       = '1;

    typedef struct packed {
        logic [ID_W-1:0]    dest;
        logic [VEC_W-1:0]   vector;
        logic [MODE_W-1:0]  mode;
        logic               level;
        logic               asrt;
        logic [SH_W-1:0]    shorthand;
        logic               to_all;
        logic [START_W-1:0] start_addr;
    } ipi_msg_t;

    function automatic ipi_msg_t build_msg(
        input logic [VEC_W-1:0]  vec,
        input logic [MODE_W-1:0] mode,
        input logic              level,
        input logic              asrt,
        input logic [SH_W-1:0]   sh,
        input logic [ID_W-1:0]   dest
    );
        ipi_msg_t m;
        m.vector     = vec;
        m.mode       = mode;
        m.level      = level;
        m.asrt       = asrt;
        m.shorthand  = sh;
        m.to_all     = (sh == SH_ALL_SELF);
        m.dest       = m.to_all ? ID_ALL : dest;
        m.start_addr = (mode == MODE_STARTUP) ? {vec, {PAGE_SHIFT{1'b0}}} : '0;
        return m;
    endfunction
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_OFFSET = 12'h300,
    parameter logic [ADDR_W-1:0] HI_OFFSET = 12'h310
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output logic              launch,
    output logic [WORD_W-1:0] hi_word,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;

    assign launch  = wr && (addr == LO_OFFSET) && !busy;
    assign hi_word = hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (launch) begin
                lo_q             <= wdata;
                lo_q[STATUS_BIT] <= 1'b0;
            end
            if (wr && addr == HI_OFFSET)
                hi_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == LO_OFFSET) begin
            rdata             = lo_q;
            rdata[STATUS_BIT] = busy;
        end else if (addr == HI_OFFSET) begin
            rdata = hi_q;
        end
    end
endmodule

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
    import ipi_cmd_pkg::*;
(
    input  logic [VEC_W-1:0]  vec,
    input  logic [MODE_W-1:0] mode,
    input  logic              level,
    input  logic              asrt,
    input  logic [SH_W-1:0]   sh,
    input  logic [ID_W-1:0]   dest,
    output ipi_msg_t          msg
);
    assign msg = build_msg(vec, mode, level, asrt, sh, dest);
endmodule

// File: rtl/ipi_cmd_launch.sv
module ipi_cmd_launch
    import ipi_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     launch,
    input  ipi_msg_t cmd,
    input  logic     ready,
    output logic     valid,
    output ipi_msg_t msg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            msg   <= '0;
        end else if (launch) begin
            valid <= 1'b1;
            msg   <= cmd;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
    import ipi_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_OFFSET = 12'h300,
    parameter logic [ADDR_W-1:0] HI_OFFSET = 12'h310
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [ID_W-1:0]    msg_dest,
    output logic [VEC_W-1:0]   msg_vector,
    output logic [MODE_W-1:0]  msg_mode,
    output logic               msg_level,
    output logic               msg_assert,
    output logic [SH_W-1:0]    msg_shorthand,
    output logic               msg_to_all,
    output logic [START_W-1:0] msg_start_addr
);
    logic              launch;
    logic [WORD_W-1:0] hi_word;
    ipi_msg_t          cmd;
    ipi_msg_t          msg;

    ipi_cmd_regs #(
        .ADDR_W(ADDR_W), .LO_OFFSET(LO_OFFSET), .HI_OFFSET(HI_OFFSET)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .busy(msg_valid), .launch(launch), .hi_word(hi_word), .rdata(bus_rdata)
    );

    ipi_cmd_decode u_dec (
        .vec  (bus_wdata[VEC_W-1:0]),
        .mode (bus_wdata[10:8]),
        .level(bus_wdata[15]),
        .asrt (bus_wdata[14]),
        .sh   (bus_wdata[19:18]),
        .dest (hi_word[WORD_W-1 -: ID_W]),
        .msg  (cmd)
    );

    ipi_cmd_launch u_launch (
        .clk(clk), .rst(rst), .launch(launch), .cmd(cmd),
        .ready(msg_ready), .valid(msg_valid), .msg(msg)
    );

    assign msg_dest       = msg.dest;
    assign msg_vector     = msg.vector;
    assign msg_mode       = msg.mode;
    assign msg_level      = msg.level;
    assign msg_assert     = msg.asrt;
    assign msg_shorthand  = msg.shorthand;
    assign msg_to_all     = msg.to_all;
    assign msg_start_addr = msg.start_addr;
endmodule

// File: rtl/ipi_cmd_checker.sv
module ipi_cmd_checker
    import ipi_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_OFFSET = 12'h300
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [ID_W-1:0]    msg_dest,
    input logic [VEC_W-1:0]   msg_vector,
    input logic [MODE_W-1:0]  msg_mode,
    input logic               msg_to_all,
    input logic [START_W-1:0] msg_start_addr
);
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest) && $stable(msg_vector) && $stable(msg_mode)); // R5

    AST_CLEAR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_valid); // R6

    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == LO_OFFSET && !msg_valid |=> msg_valid); // R3

    AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (rst)
        bus_addr == LO_OFFSET |-> bus_rdata[STATUS_BIT] == msg_valid); // R4

    AST_BCAST_DEST: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_to_all |-> msg_dest == ID_ALL); // R8

    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_mode != MODE_STARTUP |-> msg_start_addr == '0); // R9

    AST_PENDING_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready && bus_wr |=> $stable(msg_vector) && $stable(msg_dest)); // R7
endmodule

bind ipi_cmd_unit ipi_cmd_checker #(.ADDR_W(ADDR_W), .LO_OFFSET(LO_OFFSET)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_to_all(msg_to_all),
    .msg_start_addr(msg_start_addr)
);

// File: tb/ipi_cmd_unit_test.sv
module ipi_cmd_unit_test;
    localparam logic [11:0] LO = 12'h300;
    localparam logic [11:0] HI = 12'h310;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_dest;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_level;
    logic        msg_assert;
    logic [1:0]  msg_shorthand;
    logic        msg_to_all;
    logic [19:0] msg_start_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ipi_cmd_unit uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_level(msg_level), .msg_assert(msg_assert),
        .msg_shorthand(msg_shorthand), .msg_to_all(msg_to_all),
        .msg_start_addr(msg_start_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic accept();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 valid", {31'b0, msg_valid}, 32'd0);
        read_reg(LO, r); check("R1 low word", r, 32'h0);
        read_reg(HI, r); check("R1 high word", r, 32'h0);
    endtask

    task automatic t_high_word();
        logic [31:0] r;
        write_reg(HI, 32'h2A00_1234);
        read_reg(HI, r); check("R2 high readback", r, 32'h2A00_1234);
        check("R2 no launch", {31'b0, msg_valid}, 32'd0);
    endtask

    task automatic t_fixed_pending();
        logic [31:0] r;
        write_reg(LO, 32'h0000_0041);
        check("R3 valid", {31'b0, msg_valid}, 32'd1);
        check("R3 dest", {24'b0, msg_dest}, 32'h2A);
        check("R3 vector", {24'b0, msg_vector}, 32'h41);
        check("R3 mode", {29'b0, msg_mode}, 32'd0);
        check("R3 flags", {30'b0, msg_level, msg_assert}, 32'd0);
        check("R9 no start addr", {12'b0, msg_start_addr}, 32'd0);
        read_reg(LO, r); check("R4 status set", r, 32'h0000_1041);
        repeat (3) @(negedge clk);
        check("R5 held valid", {31'b0, msg_valid}, 32'd1);
        check("R5 held vector", {24'b0, msg_vector}, 32'h41);
        write_reg(LO, 32'h0000_0077);
        check("R7 vector kept", {24'b0, msg_vector}, 32'h41);
        read_reg(LO, r); check("R7 low readback kept", r, 32'h0000_1041);
        write_reg(HI, 32'h5500_0000);
        check("R10 dest kept", {24'b0, msg_dest}, 32'h2A);
        accept();
        check("R6 valid cleared", {31'b0, msg_valid}, 32'd0);
        read_reg(LO, r); check("R6 status cleared", r, 32'h0000_0041);
    endtask

    task automatic t_init_pair();
        write_reg(HI, 32'h0500_0000);
        write_reg(LO, 32'h0000_C500);
        check("R3 INIT mode", {29'b0, msg_mode}, 32'd5);
        check("R3 INIT level/assert", {30'b0, msg_level, msg_assert}, 32'd3);
        check("R3 INIT dest", {24'b0, msg_dest}, 32'h05);
        accept();
        write_reg(LO, 32'h0000_8500);
        check("R3 deassert level/assert", {30'b0, msg_level, msg_assert}, 32'd2);
        check("R8 no broadcast", {31'b0, msg_to_all}, 32'd0);
        accept();
    endtask

    task automatic t_broadcast();
        write_reg(LO, 32'h0008_8500);
        check("R8 to_all", {31'b0, msg_to_all}, 32'd1);
        check("R8 dest forced", {24'b0, msg_dest}, 32'hFF);
        check("R8 shorthand", {30'b0, msg_shorthand}, 32'd2);
        accept();
    endtask

    task automatic t_startup();
        logic [31:0] r;
        write_reg(LO, 32'h0000_1607);
        check("R9 STARTUP mode", {29'b0, msg_mode}, 32'd6);
        check("R9 start addr", {12'b0, msg_start_addr}, 32'h0000_7000);
        accept();
        read_reg(LO, r); check("R4 bit12 not stored", r, 32'h0000_0607);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_high_word();
        t_fixed_pending();
        t_init_pair();
        t_broadcast();
        t_startup();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule